// File: doc/BRIEF.md
# Table-Access Program Memory Port

This block serves a processor's table read and table write requests against a 24-bit program memory. A request names an 8-bit page and a 16-bit effective address; together they form a 24-bit program address. Bits [23:1] of that address pick a program word, and address bit 0 is a byte selector. Every access chooses a lane. The low lane covers word bits [15:0]. The high lane covers word bits [31:16]. Only bits [23:16] of the high lane are real. The top byte of the high lane is a phantom: it reads as zero and it absorbs writes.

Table writes never reach nonvolatile storage. A write whose page equals the latch page (0xFA by default) loads a small bank of 24-bit write latches, indexed by effective address bits [15:1]. A write to any other page is dropped. A read on the latch page returns latch contents. Any other read issues a synchronous read to the program memory. In both cases formatted read data appears one cycle after the request. A clear input restores every latch to the erased value 0xFFFFFF after a programming pass. A separate index port lets the programming controller fetch latch words.

Top module: `tbl_pm_port`

## Requirements
- R1: After reset, `rd_vld` is low and every latch holds 0xFFFFFF.
- R2: A read outside the latch page raises `pm_rd` with `pm_addr` = {page, ea[15:1], 0`b0`}. The returned word is that address's content. `pm_rd` is never raised for the latch page or for writes.
- R3: A low-lane word read (`req_hi`=0, `req_bm`=0) returns word bits [15:0], and ea[0] has no effect.
- R4: A high-lane word read returns {0x00, word[23:16]}, so the phantom byte reads as 0x00.
- R5: A byte read (`req_bm`=1) returns the selected byte zero-extended. ea[0]=0 selects lane bits [7:0] and ea[0]=1 selects lane bits [15:8]. A high-lane byte read with ea[0]=1 returns 0.
- R6: A write on the latch page with index ea[15:1] < NLAT in low-lane word mode sets latch bits [15:0] to `req_wdata`. Latch bits [23:16] are kept.
- R7: A low-lane byte write stores `req_wdata[7:0]` into latch bits [7:0] (ea[0]=0) or [15:8] (ea[0]=1). `req_wdata[15:8]` and the other latch bits are unaffected.
- R8: A high-lane write stores `req_wdata[7:0]` into latch bits [23:16] in word mode, or in byte mode with ea[0]=0. A high-lane byte write with ea[0]=1 targets the phantom byte and changes nothing.
- R9: A latch-page index ea[15:1] >= NLAT ignores writes and reads as 0.
- R10: Writes to pages other than the latch page change no latch.
- R11: `latch_clr` sets every latch to 0xFFFFFF on the next edge, and it wins over a write in the same cycle.
- R12: `rd_vld` is high exactly one cycle after each accepted read request and low otherwise, and `rd_data` is valid in that cycle.
- R13: `prog_word` shows the latch selected by `prog_idx` combinationally, and 0 for an index >= NLAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request valid |
| req_wr | input | 1 | 1 = table write, 0 = table read |
| req_hi | input | 1 | Lane: 1 = high, 0 = low |
| req_bm | input | 1 | 1 = byte mode, 0 = word mode |
| req_page | input | 8 | Page register value |
| req_ea | input | 16 | Effective address |
| req_wdata | input | 16 | Write data |
| latch_clr | input | 1 | Reset all latches to 0xFFFFFF |
| prog_idx | input | IDXW | Latch index for the programming controller |
| prog_word | output | 24 | Latch word at `prog_idx` |
| pm_rd | output | 1 | Program memory read strobe |
| pm_addr | output | 24 | Program memory address |
| pm_rdata | input | 24 | Program memory data, one cycle after `pm_rd` |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 16 | Formatted read data |

## Verification
The bench targets the phantom byte from both sides: high-lane byte reads with ea[0]=1 and phantom writes that carry nonzero data. A design that let the phantom through would return garbage or corrupt latch bits [23:16]. Byte writes carry junk in `req_wdata[15:8]`, so a design that used the upper source byte would corrupt the neighbouring latch byte. Out-of-range latch indices, foreign-page writes and a clear that coincides with a write are also exercised. A wrong index bound, a missing page decode or a write that beats the clear would each leave a latch word that differs from the model. Odd effective addresses in word mode check that ea[0] is ignored there.

// File: rtl/tbl_pm_pkg.sv
package tbl_pm_pkg;

  localparam logic [23:0] ERASED_WORD = 24'hFFFFFF;

  typedef struct packed {
    logic hi;
    logic bm;
    logic odd;
    logic from_lat;
    logic in_range;
  } rsel_t;

  // Lane extraction and byte selection for a returned program word
  function automatic logic [15:0] fmt_read(input logic [23:0] w, input logic hi,
                                           input logic bm, input logic odd);
    logic [15:0] lane;
    lane = hi ? {8'h00, w[23:16]} : w[15:0];
    if (bm) return {8'h00, (odd ? lane[15:8] : lane[7:0])};
    return lane;
  endfunction

endpackage

// File: rtl/tbl_pm_addr_dec.sv
module tbl_pm_addr_dec #(
  parameter int          NLAT     = 4,
  parameter logic [7:0]  LAT_PAGE = 8'hFA,
  parameter int          IDXW     = 2
) (
  input  logic [7:0]      page,
  input  logic [15:0]     ea,
  output logic [23:0]     word_addr,
  output logic            lat_page,
  output logic [IDXW-1:0] lat_idx,
  output logic            idx_ok
);

  always_comb begin
    word_addr = {page, ea[15:1], 1'b0};
    lat_page  = (page == LAT_PAGE);
    lat_idx   = ea[IDXW:1];
    idx_ok    = ({17'd0, ea[15:1]} < 32'(NLAT));
  end

endmodule

// File: rtl/tbl_pm_latch_bank.sv
module tbl_pm_latch_bank
  import tbl_pm_pkg::*;
#(
  parameter int NLAT = 4,
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            hi,
  input  logic            bm,
  input  logic            odd,
  input  logic [15:0]     wdata,
  input  logic [IDXW-1:0] rd_idx,
  output logic [23:0]     rd_word,
  input  logic [IDXW-1:0] prog_idx,
  output logic [23:0]     prog_word
);

  logic [NLAT-1:0][23:0] lat_q;
  logic [NLAT-1:0][23:0] lat_d;
  logic [NLAT-1:0]       lat_en;
  logic [23:0]           wval;
  logic [2:0]            be;

  // Byte enables over the three real bytes; phantom byte has no enable
  always_comb begin
    wval = {wdata[7:0], (bm ? {wdata[7:0], wdata[7:0]} : wdata[15:0])};
    unique case ({hi, bm, odd})
      3'b000, 3'b001:         be = 3'b011;
      3'b010:                 be = 3'b001;
      3'b011:                 be = 3'b010;
      3'b100, 3'b101, 3'b110: be = 3'b100;
      default:                be = 3'b000;
    endcase
  end

  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    always_comb begin
      lat_en[i] = clr || (wr_en && (wr_idx == IDXW'(i)));
      if (clr) begin
        lat_d[i] = ERASED_WORD;
      end else begin
        for (int k = 0; k < 3; k++)
          lat_d[i][8*k +: 8] = be[k] ? wval[8*k +: 8] : lat_q[i][8*k +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lat_q[i] <= ERASED_WORD;
      else if (lat_en[i]) lat_q[i] <= lat_d[i];
    end
  end

  always_comb begin
    rd_word   = (32'(rd_idx) < 32'(NLAT)) ? lat_q[rd_idx] : 24'd0;
    prog_word = (32'(prog_idx) < 32'(NLAT)) ? lat_q[prog_idx] : 24'd0;
  end

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> $stable(lat_q));

  a_r11_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lat_q == {NLAT{ERASED_WORD}}));

  a_r8_phantom_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hi && bm && odd && !clr) |=> $stable(lat_q));

endmodule

// File: rtl/tbl_pm_read_fmt.sv
module tbl_pm_read_fmt
  import tbl_pm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  rsel_t       sel_in,
  input  logic [23:0] lat_word,
  input  logic [23:0] pm_rdata,
  output logic        rd_vld,
  output logic [15:0] rd_data
);

  rsel_t       sel_q,  sel_d;
  logic [23:0] latw_q, latw_d;
  logic        vld_q,  vld_d;
  logic [23:0] src;

  always_comb begin
    vld_d  = rd_req;
    sel_d  = sel_q;
    latw_d = latw_q;
    if (rd_req) begin
      sel_d  = sel_in;
      latw_d = sel_in.in_range ? lat_word : 24'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sel_q  <= '0;
      latw_q <= '0;
    end else begin
      vld_q  <= vld_d;
      sel_q  <= sel_d;
      latw_q <= latw_d;
    end
  end

  always_comb begin
    src     = sel_q.from_lat ? latw_q : pm_rdata;
    rd_vld  = vld_q;
    rd_data = fmt_read(src, sel_q.hi, sel_q.bm, sel_q.odd);
  end

  a_r4_high_lane_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && sel_q.hi) |-> (rd_data[15:8] == 8'h00));

  a_r5_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && sel_q.bm) |-> (rd_data[15:8] == 8'h00));

  a_r9_oor_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && sel_q.from_lat && !sel_q.in_range) |-> (rd_data == 16'h0000));

endmodule

// File: rtl/tbl_pm_port.sv
module tbl_pm_port
  import tbl_pm_pkg::*;
#(
  parameter int         NLAT     = 4,
  parameter logic [7:0] LAT_PAGE = 8'hFA,
  localparam int        IDXW     = (NLAT > 1) ? $clog2(NLAT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_vld,
  input  logic            req_wr,
  input  logic            req_hi,
  input  logic            req_bm,
  input  logic [7:0]      req_page,
  input  logic [15:0]     req_ea,
  input  logic [15:0]     req_wdata,
  input  logic            latch_clr,
  input  logic [IDXW-1:0] prog_idx,
  output logic [23:0]     prog_word,
  output logic            pm_rd,
  output logic [23:0]     pm_addr,
  input  logic [23:0]     pm_rdata,
  output logic            rd_vld,
  output logic [15:0]     rd_data
);

  logic [23:0]     word_addr;
  logic            lat_page;
  logic [IDXW-1:0] lat_idx;
  logic            idx_ok;
  logic            rd_req;
  logic            lat_wr;
  logic [23:0]     lat_word;
  rsel_t           sel;

  tbl_pm_addr_dec #(.NLAT(NLAT), .LAT_PAGE(LAT_PAGE), .IDXW(IDXW)) u_dec (
    .page      (req_page),
    .ea        (req_ea),
    .word_addr (word_addr),
    .lat_page  (lat_page),
    .lat_idx   (lat_idx),
    .idx_ok    (idx_ok)
  );

  always_comb begin
    rd_req       = req_vld && !req_wr;
    lat_wr       = req_vld && req_wr && lat_page && idx_ok;
    pm_rd        = rd_req && !lat_page;
    pm_addr      = word_addr;
    sel.hi       = req_hi;
    sel.bm       = req_bm;
    sel.odd      = req_ea[0];
    sel.from_lat = lat_page;
    sel.in_range = idx_ok;
  end

  tbl_pm_latch_bank #(.NLAT(NLAT), .IDXW(IDXW)) u_lat (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (latch_clr),
    .wr_en     (lat_wr),
    .wr_idx    (lat_idx),
    .hi        (req_hi),
    .bm        (req_bm),
    .odd       (req_ea[0]),
    .wdata     (req_wdata),
    .rd_idx    (lat_idx),
    .rd_word   (lat_word),
    .prog_idx  (prog_idx),
    .prog_word (prog_word)
  );

  tbl_pm_read_fmt u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .sel_in   (sel),
    .lat_word (lat_word),
    .pm_rdata (pm_rdata),
    .rd_vld   (rd_vld),
    .rd_data  (rd_data)
  );

  a_r12_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_wr) |=> rd_vld);

  a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_vld && !req_wr) |=> !rd_vld);

  a_r2_no_pm_on_latch_page: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd |-> (pm_addr[23:16] != LAT_PAGE));

  a_r10_no_pm_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_wr) |-> !pm_rd);

endmodule

// File: tb/tbl_pm_port_bench.sv
`timescale 1ns/1ps
module tbl_pm_port_bench;
  localparam int NLAT = 4;
  localparam int IDXW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 0, req_wr = 0, req_hi = 0, req_bm = 0, latch_clr = 0;
  logic [7:0]  req_page = 0;
  logic [15:0] req_ea = 0, req_wdata = 0;
  logic [IDXW-1:0] prog_idx = 0;
  logic [23:0] prog_word, pm_addr;
  logic [23:0] pm_rdata = 0;
  logic        pm_rd, rd_vld;
  logic [15:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R12", exp_tag = "R12";

  always #2.5 clk = ~clk;

  tbl_pm_port #(.NLAT(NLAT)) u_tbl_pm_port (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr), .req_hi(req_hi),
    .req_bm(req_bm), .req_page(req_page), .req_ea(req_ea), .req_wdata(req_wdata),
    .latch_clr(latch_clr), .prog_idx(prog_idx), .prog_word(prog_word),
    .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .rd_vld(rd_vld), .rd_data(rd_data));

  function automatic logic [23:0] pm_fn(input logic [23:0] a);
    return {a[15:8] ^ a[23:16] ^ 8'h3C, a[7:0] ^ 8'hC3, a[15:8] + 8'h11};
  endfunction

  // Behavioural program memory: one-cycle synchronous read
  always @(posedge clk) if (pm_rd) pm_rdata <= pm_fn(pm_addr);

  // Reference model
  logic [23:0] mlat [NLAT];
  logic        exp_vld;
  logic [15:0] exp_data;
  logic [31:0] w32;
  int          bsel, idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLAT; i++) mlat[i] <= 24'hFFFFFF;
      exp_vld <= 1'b0;
      exp_data <= 16'h0;
    end else begin
      idx  = int'(req_ea[15:1]);
      bsel = (req_hi ? 2 : 0) + (req_bm ? int'(req_ea[0]) : 0);
      exp_vld <= req_vld && !req_wr;
      exp_tag <= cur_tag;
      if (req_vld && !req_wr) begin
        if (req_page == 8'hFA) w32 = {8'h00, (idx < NLAT) ? mlat[idx] : 24'h0};
        else                   w32 = {8'h00, pm_fn({req_page, req_ea[15:1], 1'b0})};
        if (req_bm) exp_data <= {8'h00, w32[8*bsel +: 8]};
        else        exp_data <= w32[8*bsel +: 16];
      end
      if (latch_clr) begin
        for (int i = 0; i < NLAT; i++) mlat[i] <= 24'hFFFFFF;
      end else if (req_vld && req_wr && req_page == 8'hFA && idx < NLAT) begin
        w32 = {8'h00, mlat[idx]};
        w32[8*bsel +: 8] = req_wdata[7:0];
        if (!req_bm) w32[8*bsel + 8 +: 8] = req_wdata[15:8];
        mlat[idx] <= w32[23:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk({exp_tag, " valid"}, 32'(rd_vld), 32'(exp_vld));
    if (exp_vld) chk({exp_tag, " data"}, 32'(rd_data), 32'(exp_data));
    chk("R13 prog_word", 32'(prog_word), 32'(mlat[prog_idx]));
  end

  task automatic op(input string tag, input logic wr, input logic hi, input logic bm,
                    input logic [7:0] pg, input logic [15:0] ea, input logic [15:0] wd);
    @(posedge clk); #1;
    cur_tag = tag; req_vld = 1; req_wr = wr; req_hi = hi; req_bm = bm;
    req_page = pg; req_ea = ea; req_wdata = wd; latch_clr = 0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_vld = 0; req_wr = 0; latch_clr = 0;
  endtask

  task automatic sweep_latches(input string tag);
    for (int i = 0; i < NLAT + 2; i++) begin
      op(tag, 0, 0, 0, 8'hFA, 16'(2*i), 16'h0);
      op(tag, 0, 1, 0, 8'hFA, 16'(2*i), 16'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset valid", 32'(rd_vld), 32'd0);
    for (int i = 0; i < NLAT; i++) begin
      prog_idx = IDXW'(i); #0.1;
      chk("R1 reset latch", 32'(prog_word), 32'hFFFFFF);
    end
    sweep_latches("R1");
    // R2 R3: program memory word reads, odd ea ignored
    op("R2", 0, 0, 0, 8'h12, 16'h3456, 0);
    op("R3", 0, 0, 0, 8'h01, 16'h0003, 0);
    op("R3", 0, 0, 0, 8'h7E, 16'hFFFF, 0);
    idle();
    op("R4", 0, 1, 0, 8'h22, 16'h1000, 0);
    op("R4", 0, 1, 0, 8'h22, 16'h1001, 0);
    for (int k = 0; k < 4; k++) op("R5", 0, k[1], 1, 8'h33, 16'(16'h0ab0 + k[0]), 0);
    op("R5", 0, 1, 1, 8'h33, 16'h0ab1, 0);
    idle();
    // Latch writes
    op("R6", 1, 0, 0, 8'hFA, 16'h0000, 16'h1234);
    op("R6", 1, 0, 0, 8'hFA, 16'h0003, 16'hBEEF);
    op("R7", 1, 0, 1, 8'hFA, 16'h0004, 16'hEE5A);
    op("R7", 1, 0, 1, 8'hFA, 16'h0005, 16'h77A5);
    op("R8", 1, 1, 0, 8'hFA, 16'h0000, 16'h99C1);
    op("R8", 1, 1, 1, 8'hFA, 16'h0006, 16'h0042);
    op("R8", 1, 1, 1, 8'hFA, 16'h0007, 16'h00DD);
    op("R8", 1, 1, 1, 8'hFA, 16'h0003, 16'hFF13);
    sweep_latches("R6");
    for (int k = 0; k < 8; k++) op("R5", 0, k[2], k[1], 8'hFA, 16'(16'h0002 + k[0]), 0);
    // R9: out of range
    op("R9", 1, 0, 0, 8'hFA, 16'h0008, 16'h0BAD);
    op("R9", 1, 1, 0, 8'hFA, 16'h000A, 16'h0BAD);
    op("R9", 0, 0, 0, 8'hFA, 16'h0008, 0);
    op("R9", 0, 1, 0, 8'hFA, 16'h000A, 0);
    // R10: foreign page writes
    op("R10", 1, 0, 0, 8'hFB, 16'h0000, 16'h0000);
    op("R10", 1, 1, 0, 8'h12, 16'h0002, 16'h0000);
    sweep_latches("R10");
    // R11: clear, and clear colliding with a write
    @(posedge clk); #1; cur_tag = "R11"; req_vld = 0; latch_clr = 1;
    idle();
    sweep_latches("R11");
    op("R11", 1, 0, 0, 8'hFA, 16'h0002, 16'h0101);
    @(posedge clk); #1; req_vld = 1; req_wr = 1; req_ea = 16'h0004; latch_clr = 1;
    idle();
    sweep_latches("R11");
    // R12 R13: mixed traffic
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      @(posedge clk); #1;
      cur_tag = "R12";
      req_vld = lf[0]; req_wr = lf[1]; req_hi = lf[2]; req_bm = lf[3];
      req_page = lf[5:4] == 2'b00 ? 8'h12 : (lf[5:4] == 2'b01 ? 8'h7E : 8'hFA);
      req_ea = {12'h0, lf[9:6]}; req_wdata = {lf[15:8], lf[7:0] ^ 8'h5A};
      latch_clr = (lf[15:11] == 5'h1F);
      prog_idx = lf[11:10];
    end
    idle();
    idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule